// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation buffer from memory after a lookup has found no entry. A start pulse hands it the faulting virtual address and a read/write flag. The walker then finds the page directory and reads one directory word. It reads the two page-table words for the even/odd page pair. It converts both words from their stored software layout into hardware entry-low values and pulses a write strobe toward the translation buffer. It then reports whether the faulting access may proceed.

The directory base is not configured directly. After reset, the first walk looks at two instructions placed at the exception base and decodes their 16-bit immediates. Together these give the kernel address of a memory word that holds the current directory base. A plausible pointer is kept and used by every later walk. Every pointer in the tables is a kernel-segment address, and the walker subtracts the segment base from it before it issues a read. While a walk is active, the walker drives substitute values for the context, entry-high and bad-address registers. When the walk ends, the caller's own values appear again.

Memory is reached through one 32-bit word-read port with a valid/ready handshake. A read completes in the cycle where `mem_valid_o` and `mem_ready_i` are both high, and `mem_rdata_i` carries the data in that same cycle.

Top module: `pgwalk_top`

## Requirements
- R1: `start_i` is taken only while the walker is idle. A start that arrives during a walk or in its done cycle has no effect. Each accepted start produces exactly one single-cycle `done_o`, and `result_o` is valid in that cycle.
- R2: The directory read goes to (B − 0x80000000) + VA[31:22]·4. Here B is the nonzero directory base word read from the stored pointer address.
- R3: The page-table pair is read at (P − 0x80000000) + VA[21:13]·8, where P is the directory word. The even word is read first and the odd word at the next address plus 4.
- R4: Each entry-low value is the page-table word shifted right by 6. `refill_we_o` pulses for one cycle once per walk that reads both words, with `lo_even_o`/`lo_odd_o` holding the two values. `done_o` follows two cycles after that pulse.
- R5: The half is chosen by VA[12] (0 even, 1 odd). In that half, bit 1 means valid and bit 2 means writable. The result codes are 2 (invalid) when valid is clear, 3 (dirty) for a write without writable, and 0 (match) otherwise.
- R6: If the directory base word reads as zero, the walk ends with code 1 (no-match). It then makes no directory or page-table read and no refill pulse.
- R7: Discovery reads the word at EBase − 0x80000000 and then the word 8 bytes further on. The candidate is (first[15:0] << 16) plus the sign-extended second[15:0]. It is accepted only when it is strictly between 0x80000000 and 0xA0000000, and it is then stored as candidate − 0x80000000. A rejected candidate ends the walk with code 1.
- R8: Discovery runs at most once after reset. After an accepted pointer, every later walk starts with the base read. After a rejection, every later walk ends with code 1 and makes no memory read.
- R9: While a walk is active, `badva_o` equals VA. `ctx_o` equals (ctx_i & ~0x7FFFFF) | ((VA >> 9) & 0x7FFFF0). `ehi_o` equals VA[31:13] with bits 12:8 zero and ehi_i[7:0] kept. When idle or done, all three equal their inputs.
- R10: Once raised, `mem_valid_o` and `mem_addr_o` hold steady until `mem_ready_i` is seen.
- R11: During and right after reset, `mem_valid_o`, `refill_we_o` and `done_o` are low. No discovery has taken place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Walk request pulse |
| va_i | input | 32 | Faulting virtual address |
| write_i | input | 1 | 1 when the faulting access is a write |
| ebase_i | input | 32 | Exception base (kernel address) |
| ctx_i | input | 32 | Current context register value |
| ehi_i | input | 32 | Current entry-high register value |
| badva_i | input | 32 | Current bad-address register value |
| ctx_o | output | 32 | Context value in effect |
| ehi_o | output | 32 | Entry-high value in effect |
| badva_o | output | 32 | Bad-address value in effect |
| mem_valid_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Physical byte address of the read |
| mem_ready_i | input | 1 | Read accepted, data valid |
| mem_rdata_i | input | 32 | Read data |
| refill_we_o | output | 1 | Refill write strobe |
| lo_even_o | output | 32 | Entry-low for the even page |
| lo_odd_o | output | 32 | Entry-low for the odd page |
| done_o | output | 1 | Walk finished pulse |
| result_o | output | 2 | 0 match, 1 no-match, 2 invalid, 3 dirty |

## Verification
The assertions assume that the memory side answers every request eventually, and that `mem_ready_i` carries no meaning while `mem_valid_o` is low. The bench responder meets both assumptions. It raises ready only against a live request, and it does so at random in three cycles out of four. This stretches request hold times without ever stalling a walk. Start requests are issued only once the previous done pulse has been seen, apart from deliberate extra pulses placed in the middle of long walks. Every table pointer returned by the bench memory is a kernel-segment address, so every walk stays inside the address regions the bench models.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DISC_LO,
      ST_DISC_HI,
      ST_BASE,
      ST_DIR,
      ST_PTE_EV,
      ST_PTE_OD,
      ST_REFILL,
      ST_CHECK,
      ST_DONE
   } pw_state_e;

   typedef enum logic [1:0] {
      RES_MATCH   = 2'd0,
      RES_NOMATCH = 2'd1,
      RES_INVALID = 2'd2,
      RES_DIRTY   = 2'd3
   } pw_res_e;

endpackage

// File: rtl/pgwalk_probe.sv
module pgwalk_probe #(
   parameter int unsigned     AW         = 32,
   parameter int unsigned     IMM_W      = 16,
   parameter logic [AW-1:0]   KSEG_BASE  = 32'h8000_0000,
   parameter logic [AW-1:0]   KSEG_LIMIT = 32'hA000_0000
) (
   input  logic [IMM_W-1:0] imm_hi,
   input  logic [IMM_W-1:0] imm_lo,
   output logic             cand_ok,
   output logic [AW-1:0]    cand_phys
);

   logic [AW-1:0] cand;

   always_comb begin
      cand      = (AW'(imm_hi) << IMM_W) + AW'($signed(imm_lo));
      cand_ok   = (cand > KSEG_BASE) && (cand < KSEG_LIMIT);
      cand_phys = cand - KSEG_BASE;
   end

endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr
   import pgwalk_pkg::*;
#(
   parameter int unsigned   AW         = 32,
   parameter int unsigned   DIR_SHIFT  = 22,
   parameter int unsigned   PAIR_SHIFT = 13,
   parameter int unsigned   PROBE_GAP  = 8,
   parameter logic [AW-1:0] KSEG_BASE  = 32'h8000_0000,
   localparam int unsigned  PW         = AW - PAIR_SHIFT
) (
   input  pw_state_e       st,
   input  logic [AW-1:0]   ebase,
   input  logic [AW-1:0]   ptr,
   input  logic [AW-1:0]   dir_base,
   input  logic [AW-1:0]   pt_base,
   input  logic [PW-1:0]   va_pair,
   output logic [AW-1:0]   addr
);

   localparam int unsigned   IDX_W    = DIR_SHIFT - PAIR_SHIFT;
   localparam logic [PW-1:0] IDX_MASK = PW'((64'd1 << IDX_W) - 64'd1);
   localparam int unsigned   WORD_B   = 4;

   logic [AW-1:0] dir_off;
   logic [AW-1:0] pte_off;

   always_comb begin
      dir_off = AW'(va_pair >> IDX_W) << 2;
      pte_off = AW'(va_pair & IDX_MASK) << 3;
      unique case (st)
         ST_DISC_LO: addr = ebase - KSEG_BASE;
         ST_DISC_HI: addr = ebase - KSEG_BASE + AW'(PROBE_GAP);
         ST_BASE:    addr = ptr;
         ST_DIR:     addr = dir_base - KSEG_BASE + dir_off;
         ST_PTE_EV:  addr = pt_base - KSEG_BASE + pte_off;
         ST_PTE_OD:  addr = pt_base - KSEG_BASE + pte_off + AW'(WORD_B);
         default:    addr = '0;
      endcase
   end

endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
   import pgwalk_pkg::*;
#(
   parameter int unsigned HALVES = 2
) (
   input  logic [HALVES-1:0] half_valid,
   input  logic [HALVES-1:0] half_wr,
   input  logic              sel,
   input  logic              is_write,
   output pw_res_e           res
);

   pw_res_e half_res [HALVES];

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      always_comb begin
         if (!half_valid[h])
            half_res[h] = RES_INVALID;
         else if (is_write && !half_wr[h])
            half_res[h] = RES_DIRTY;
         else
            half_res[h] = RES_MATCH;
      end
   end

   assign res = half_res[sel];

endmodule

// File: rtl/pgwalk_ovr.sv
module pgwalk_ovr #(
   parameter int unsigned   AW         = 32,
   parameter int unsigned   PAIR_SHIFT = 13,
   parameter int unsigned   CTX_SHIFT  = 9,
   parameter int unsigned   ASID_W     = 8,
   parameter logic [AW-1:0] CTX_WIN    = 32'h007F_FFFF,
   parameter logic [AW-1:0] CTX_FIELD  = 32'h007F_FFF0
) (
   input  logic          active,
   input  logic [AW-1:0] va,
   input  logic [AW-1:0] ctx_i,
   input  logic [AW-1:0] ehi_i,
   input  logic [AW-1:0] badva_i,
   output logic [AW-1:0] ctx_o,
   output logic [AW-1:0] ehi_o,
   output logic [AW-1:0] badva_o
);

   localparam logic [AW-1:0] PAIR_LOW  = AW'((64'd1 << PAIR_SHIFT) - 64'd1);
   localparam logic [AW-1:0] ASID_MASK = AW'((64'd1 << ASID_W) - 64'd1);

   always_comb begin
      if (active) begin
         ctx_o   = (ctx_i & ~CTX_WIN) | ((va >> CTX_SHIFT) & CTX_FIELD);
         ehi_o   = (va & ~PAIR_LOW) | (ehi_i & ASID_MASK);
         badva_o = va;
      end else begin
         ctx_o   = ctx_i;
         ehi_o   = ehi_i;
         badva_o = badva_i;
      end
   end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
   import pgwalk_pkg::*;
#(
   parameter int unsigned   AW           = 32,
   parameter int unsigned   IMM_W        = 16,
   parameter int unsigned   SW_SHIFT     = 6,
   parameter int unsigned   DIR_SHIFT    = 22,
   parameter int unsigned   PAIR_SHIFT   = 13,
   parameter int unsigned   PROBE_GAP    = 8,
   parameter int unsigned   VALID_BIT    = 1,
   parameter int unsigned   WRITE_BIT    = 2,
   parameter logic [AW-1:0] KSEG_BASE    = 32'h8000_0000,
   parameter logic [AW-1:0] KSEG_LIMIT   = 32'hA000_0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] va_i,
   input  logic          write_i,
   input  logic [AW-1:0] ebase_i,
   input  logic [AW-1:0] ctx_i,
   input  logic [AW-1:0] ehi_i,
   input  logic [AW-1:0] badva_i,
   output logic [AW-1:0] ctx_o,
   output logic [AW-1:0] ehi_o,
   output logic [AW-1:0] badva_o,
   output logic          mem_valid_o,
   output logic [AW-1:0] mem_addr_o,
   input  logic          mem_ready_i,
   input  logic [AW-1:0] mem_rdata_i,
   output logic          refill_we_o,
   output logic [AW-1:0] lo_even_o,
   output logic [AW-1:0] lo_odd_o,
   output logic          done_o,
   output logic [1:0]    result_o
);

   localparam int unsigned SEL_BIT = PAIR_SHIFT - 1;
   localparam int unsigned PW      = AW - PAIR_SHIFT;

   if (AW != 32) begin : g_bad_aw
      $error("pgwalk_top: AW must be 32");
   end
   if (DIR_SHIFT <= PAIR_SHIFT || DIR_SHIFT >= AW) begin : g_bad_dir
      $error("pgwalk_top: DIR_SHIFT must lie above PAIR_SHIFT and below AW");
   end
   if (SW_SHIFT >= AW || IMM_W >= AW) begin : g_bad_shift
      $error("pgwalk_top: SW_SHIFT and IMM_W must be below AW");
   end
   if (VALID_BIT >= AW - SW_SHIFT || WRITE_BIT >= AW - SW_SHIFT) begin : g_bad_bits
      $error("pgwalk_top: flag bits fall outside the entry-low value");
   end
   if (KSEG_LIMIT <= KSEG_BASE) begin : g_bad_kseg
      $error("pgwalk_top: KSEG_LIMIT must exceed KSEG_BASE");
   end

   pw_state_e         st_q, st_d;
   pw_res_e           res_q, res_d, perm_res;
   logic [AW-1:0]     va_q, ptr_q, dir_q, pt_q, lo_ev_q, lo_od_q;
   logic [IMM_W-1:0]  imm_hi_q;
   logic              wr_q, ptr_ok_q, probed_q;
   logic              hs, cand_ok, walk_active;
   logic [AW-1:0]     cand_phys;

   assign mem_valid_o = (st_q == ST_DISC_LO) || (st_q == ST_DISC_HI) || (st_q == ST_BASE) ||
                        (st_q == ST_DIR) || (st_q == ST_PTE_EV) || (st_q == ST_PTE_OD);
   assign hs          = mem_valid_o && mem_ready_i;
   assign walk_active = (st_q != ST_IDLE) && (st_q != ST_DONE);

   pgwalk_probe #(
      .AW(AW), .IMM_W(IMM_W), .KSEG_BASE(KSEG_BASE), .KSEG_LIMIT(KSEG_LIMIT)
   ) u_probe (
      .imm_hi    (imm_hi_q),
      .imm_lo    (mem_rdata_i[IMM_W-1:0]),
      .cand_ok   (cand_ok),
      .cand_phys (cand_phys)
   );

   pgwalk_addr #(
      .AW(AW), .DIR_SHIFT(DIR_SHIFT), .PAIR_SHIFT(PAIR_SHIFT),
      .PROBE_GAP(PROBE_GAP), .KSEG_BASE(KSEG_BASE)
   ) u_addr (
      .st       (st_q),
      .ebase    (ebase_i),
      .ptr      (ptr_q),
      .dir_base (dir_q),
      .pt_base  (pt_q),
      .va_pair  (va_q[AW-1:AW-PW]),
      .addr     (mem_addr_o)
   );

   pgwalk_perm #(.HALVES(2)) u_perm (
      .half_valid ({lo_od_q[VALID_BIT], lo_ev_q[VALID_BIT]}),
      .half_wr    ({lo_od_q[WRITE_BIT], lo_ev_q[WRITE_BIT]}),
      .sel        (va_q[SEL_BIT]),
      .is_write   (wr_q),
      .res        (perm_res)
   );

   pgwalk_ovr #(.AW(AW), .PAIR_SHIFT(PAIR_SHIFT)) u_ovr (
      .active  (walk_active),
      .va      (va_q),
      .ctx_i   (ctx_i),
      .ehi_i   (ehi_i),
      .badva_i (badva_i),
      .ctx_o   (ctx_o),
      .ehi_o   (ehi_o),
      .badva_o (badva_o)
   );

   always_comb begin
      st_d  = st_q;
      res_d = res_q;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               if (ptr_ok_q)
                  st_d = ST_BASE;
               else if (!probed_q)
                  st_d = ST_DISC_LO;
               else begin
                  st_d  = ST_DONE;
                  res_d = RES_NOMATCH;
               end
            end
         end
         ST_DISC_LO: if (hs) st_d = ST_DISC_HI;
         ST_DISC_HI: begin
            if (hs) begin
               if (cand_ok)
                  st_d = ST_BASE;
               else begin
                  st_d  = ST_DONE;
                  res_d = RES_NOMATCH;
               end
            end
         end
         ST_BASE: begin
            if (hs) begin
               if (mem_rdata_i == '0) begin
                  st_d  = ST_DONE;
                  res_d = RES_NOMATCH;
               end else
                  st_d = ST_DIR;
            end
         end
         ST_DIR:    if (hs) st_d = ST_PTE_EV;
         ST_PTE_EV: if (hs) st_d = ST_PTE_OD;
         ST_PTE_OD: if (hs) st_d = ST_REFILL;
         ST_REFILL: st_d = ST_CHECK;
         ST_CHECK: begin
            st_d  = ST_DONE;
            res_d = perm_res;
         end
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         res_q    <= RES_NOMATCH;
         va_q     <= '0;
         wr_q     <= 1'b0;
         ptr_q    <= '0;
         ptr_ok_q <= 1'b0;
         probed_q <= 1'b0;
         imm_hi_q <= '0;
         dir_q    <= '0;
         pt_q     <= '0;
         lo_ev_q  <= '0;
         lo_od_q  <= '0;
      end else begin
         st_q  <= st_d;
         res_q <= res_d;
         if (st_q == ST_IDLE && start_i) begin
            va_q <= va_i;
            wr_q <= write_i;
            if (!ptr_ok_q && !probed_q)
               probed_q <= 1'b1;
         end
         if (hs) begin
            unique case (st_q)
               ST_DISC_LO: imm_hi_q <= mem_rdata_i[IMM_W-1:0];
               ST_DISC_HI: begin
                  if (cand_ok) begin
                     ptr_q    <= cand_phys;
                     ptr_ok_q <= 1'b1;
                  end
               end
               ST_BASE:   dir_q   <= mem_rdata_i;
               ST_DIR:    pt_q    <= mem_rdata_i;
               ST_PTE_EV: lo_ev_q <= mem_rdata_i >> SW_SHIFT;
               ST_PTE_OD: lo_od_q <= mem_rdata_i >> SW_SHIFT;
               default: ;
            endcase
         end
      end
   end

   assign refill_we_o = (st_q == ST_REFILL);
   assign lo_even_o   = lo_ev_q;
   assign lo_odd_o    = lo_od_q;
   assign done_o      = (st_q == ST_DONE);
   assign result_o    = res_q;

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
   parameter int unsigned AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] ctx_i,
   input logic [AW-1:0] ehi_i,
   input logic [AW-1:0] badva_i,
   input logic [AW-1:0] ctx_o,
   input logic [AW-1:0] ehi_o,
   input logic [AW-1:0] badva_o,
   input logic          mem_valid_o,
   input logic [AW-1:0] mem_addr_o,
   input logic          mem_ready_i,
   input logic          refill_we_o,
   input logic [AW-1:0] lo_even_o,
   input logic [AW-1:0] lo_odd_o,
   input logic          done_o,
   input logic [1:0]    result_o
);

   // R1: done is a single-cycle pulse and no read overlaps it
   p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !mem_valid_o && !refill_we_o);

   // R4: refill strobe is one cycle wide and done follows two cycles later
   p_refill_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      refill_we_o |=> !refill_we_o ##1 done_o);
   p_lo_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      refill_we_o |-> (lo_even_o[AW-1:AW-6] == 6'd0) && (lo_odd_o[AW-1:AW-6] == 6'd0));

   // R5/R6: any code other than no-match comes from a walk that refilled
   p_code_needs_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && result_o != 2'd1) |-> $past(refill_we_o, 2));

   // R9: overrides while reading, caller values back at done
   p_override_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid_o |-> (ctx_o[AW-1:23] == ctx_i[AW-1:23]) && (ctx_o[3:0] == 4'd0) &&
                      (ehi_o[12:8] == 5'd0) && (ehi_o[7:0] == ehi_i[7:0]));
   p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ctx_o == ctx_i) && (ehi_o == ehi_i) && (badva_o == badva_i));

   // R10: request held until accepted
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid_o && !mem_ready_i) |=> mem_valid_o && $stable(mem_addr_o));

endmodule

bind pgwalk_top pgwalk_chk #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctx_i       (ctx_i),
   .ehi_i       (ehi_i),
   .badva_i     (badva_i),
   .ctx_o       (ctx_o),
   .ehi_o       (ehi_o),
   .badva_o     (badva_o),
   .mem_valid_o (mem_valid_o),
   .mem_addr_o  (mem_addr_o),
   .mem_ready_i (mem_ready_i),
   .refill_we_o (refill_we_o),
   .lo_even_o   (lo_even_o),
   .lo_odd_o    (lo_odd_o),
   .done_o      (done_o),
   .result_o    (result_o)
);

// File: tb/pgwalk_top_bench.sv
module pgwalk_top_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] KB = 32'h8000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] va_i = '0;
   logic        write_i = 1'b0;
   logic [31:0] ebase_i = 32'h8000_1000;
   logic [31:0] ctx_in = '0, ehi_in = '0, badva_in = '0;
   logic [31:0] ctx_o, ehi_o, badva_o;
   logic        mem_valid_o;
   logic [31:0] mem_addr_o;
   logic        mem_ready_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;
   logic        refill_we_o;
   logic [31:0] lo_even_o, lo_odd_o;
   logic        done_o;
   logic [1:0]  result_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgwalk_top u_pgwalk_top (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .va_i(va_i), .write_i(write_i),
      .ebase_i(ebase_i), .ctx_i(ctx_in), .ehi_i(ehi_in), .badva_i(badva_in),
      .ctx_o(ctx_o), .ehi_o(ehi_o), .badva_o(badva_o),
      .mem_valid_o(mem_valid_o), .mem_addr_o(mem_addr_o),
      .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
      .refill_we_o(refill_we_o), .lo_even_o(lo_even_o), .lo_odd_o(lo_odd_o),
      .done_o(done_o), .result_o(result_o)
   );

   int nchk = 0, nfail = 0, cyc = 0;
   logic [31:0] ovr [logic [31:0]];

   // monitor state
   logic [31:0] rd_log [8];
   int          nrd = 0, nref = 0, ndone = 0, ovr_bad = 0, hold_bad = 0;
   logic [31:0] seen_ev = '0, seen_od = '0;
   logic [1:0]  seen_res = '0;
   logic [31:0] cur_va = '0;
   logic        prev_wait = 1'b0;
   logic [31:0] prev_addr = '0;

   // reference model state
   bit          m_probed = 0, m_ptr_ok = 0;
   logic [31:0] m_ptr = '0;

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      if (ovr.exists(a)) return ovr[a];
      if (a >= 32'h0040_0000 && a < 32'h0040_1000)
         return 32'h8050_0000 + ((a - 32'h0040_0000) << 10);
      return (a * 32'h9E37_79B1) ^ (a >> 7) ^ 32'h5A5A_1234;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory responder and output monitor, all at the falling edge
   always @(negedge clk) begin
      if (prev_wait && !(mem_valid_o && mem_addr_o == prev_addr)) hold_bad++;
      prev_wait   = 1'b0;
      mem_ready_i = 1'b0;
      if (mem_valid_o) begin
         mem_rdata_i = mem_word(mem_addr_o);
         mem_ready_i = ($urandom % 4) != 0;
         if (mem_ready_i) begin
            if (nrd < 8) rd_log[nrd] = mem_addr_o;
            nrd++;
         end else begin
            prev_wait = 1'b1;
            prev_addr = mem_addr_o;
         end
         if (badva_o != cur_va ||
             ctx_o != ((ctx_in & ~32'h007F_FFFF) | ((cur_va >> 9) & 32'h007F_FFF0)) ||
             ehi_o != ({cur_va[31:13], 13'd0} | {24'd0, ehi_in[7:0]}))
            ovr_bad++;
      end
      if (refill_we_o) begin
         nref++;
         seen_ev = lo_even_o;
         seen_od = lo_odd_o;
      end
      if (done_o) begin
         ndone++;
         seen_res = result_o;
         if (ctx_o != ctx_in || ehi_o != ehi_in || badva_o != badva_in) ovr_bad++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      m_probed = 0;
      m_ptr_ok = 0;
      repeat (3) @(negedge clk);
      chk(!done_o && !mem_valid_o && !refill_we_o, "R11 reset outputs",
          {29'd0, done_o, mem_valid_o, refill_we_o}, 32'd0);
      chk(ctx_o == ctx_in && badva_o == badva_in, "R11 passthrough at reset", ctx_o, ctx_in);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_walk(input logic [31:0] va, input logic wr, input bit poke, input string tag);
      logic [31:0] ea [8];
      int          ne = 0;
      logic [1:0]  er = 2'd1;
      logic [31:0] ee = '0, eo = '0, w, sel;
      bit          erefill = 0, full;
      logic [31:0] cand;
      bit          ok;
      // model from the requirements
      full = m_ptr_ok;
      if (!m_ptr_ok && !m_probed) begin
         m_probed = 1;
         ea[ne++] = ebase_i - KB;
         ea[ne++] = ebase_i - KB + 32'd8;
         cand = {mem_word(ebase_i - KB)[15:0], 16'd0} +
                {{16{mem_word(ebase_i - KB + 32'd8)[15]}}, mem_word(ebase_i - KB + 32'd8)[15:0]};
         if (cand > KB && cand < 32'hA000_0000) begin
            m_ptr_ok = 1;
            m_ptr = cand - KB;
         end
      end
      if (m_ptr_ok) begin
         ea[ne++] = m_ptr;
         w = mem_word(m_ptr);
         if (w != 0) begin
            ea[ne] = w - KB + {20'd0, va[31:22], 2'b00};
            w = mem_word(ea[ne]);
            ne++;
            ea[ne++] = w - KB + {20'd0, va[21:13], 3'b000};
            ea[ne++] = w - KB + {20'd0, va[21:13], 3'b000} + 32'd4;
            ee = mem_word(ea[ne-2]) >> 6;
            eo = mem_word(ea[ne-1]) >> 6;
            erefill = 1;
            sel = va[12] ? eo : ee;
            if (!sel[1]) er = 2'd2;
            else if (wr && !sel[2]) er = 2'd3;
            else er = 2'd0;
         end
      end
      // drive
      nrd = 0; nref = 0; ndone = 0; ovr_bad = 0; hold_bad = 0;
      ctx_in = $urandom; ehi_in = $urandom; badva_in = $urandom;
      cur_va = va;
      @(negedge clk);
      start_i = 1'b1; va_i = va; write_i = wr;
      @(negedge clk);
      start_i = 1'b0;
      if (poke && full) begin
         @(negedge clk);
         start_i = 1'b1; va_i = va ^ 32'hFFC0_3000; write_i = !wr;
         @(negedge clk);
         start_i = 1'b0;
      end
      for (int i = 0; i < 400 && ndone == 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
      // compare
      chk(ndone == 1, {tag, " R1 one done per start"}, ndone, 1);
      ok = (nrd == ne);
      for (int i = 0; i < ne && i < 8; i++) if (rd_log[i] != ea[i]) ok = 0;
      chk(ok, {tag, " R2 R3 R7 R8 read sequence"}, nrd, ne);
      chk(nref == int'(erefill), {tag, " R4 R6 refill count"}, nref, {31'd0, erefill});
      if (erefill)
         chk(seen_ev == ee && seen_od == eo, {tag, " R4 entry-low values"}, seen_ev ^ seen_od, ee ^ eo);
      chk(seen_res == er, {tag, " R5 result code"}, {30'd0, seen_res}, {30'd0, er});
      chk(ovr_bad == 0, {tag, " R9 register overrides"}, ovr_bad, 0);
      chk(hold_bad == 0, {tag, " R10 request hold"}, hold_bad, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // rejected discovery: candidate 0x00001000
      ovr[32'h0000_1000] = 32'h3C1B_0000;
      ovr[32'h0000_1008] = 32'h8F7B_1000;
      do_reset();
      do_walk(32'h1234_5000, 1'b0, 0, "R7 reject low");
      do_walk(32'h0040_2000, 1'b1, 0, "R8 no retry");
      // boundary 0x80000000 rejected
      ovr[32'h0000_1000] = 32'h3C1B_8000;
      ovr[32'h0000_1008] = 32'h8F7B_0000;
      do_reset();
      do_walk(32'h0000_3000, 1'b0, 0, "R7 lower bound");
      // boundary 0xA0000000 rejected
      ovr[32'h0000_1000] = 32'h3C1B_A000;
      do_reset();
      do_walk(32'h0000_3000, 1'b0, 0, "R7 upper bound");
      // accepted: 0x80330000 + sext(0xB000) = 0x8032B000
      ovr[32'h0000_1000] = 32'h3C1B_8033;
      ovr[32'h0000_1008] = 32'h8F7B_B000;
      ovr[32'h0032_B000] = 32'h8040_0000;
      do_reset();
      do_walk(32'h0000_2000, 1'b0, 0, "R7 accept");
      do_walk(32'h0000_2000, 1'b1, 0, "R8 reuse");
      for (int i = 0; i < 40; i++)
         do_walk($urandom, 1'($urandom % 2), (i % 4) == 0, "random");
      // directed permission cases on the pair at 0x500008
      ovr[32'h0050_0008] = 32'h0000_0000;
      ovr[32'h0050_000C] = 32'h0000_0080;
      do_walk(32'h0000_2000, 1'b0, 0, "R5 invalid even");
      do_walk(32'h0000_3000, 1'b1, 0, "R5 dirty odd");
      do_walk(32'h0000_3000, 1'b0, 1, "R5 read match");
      ovr[32'h0050_000C] = 32'h0000_0180;
      do_walk(32'h0000_3000, 1'b1, 0, "R5 write match");
      // zero directory base
      ovr[32'h0032_B000] = 32'h0000_0000;
      do_walk(32'h7654_3000, 1'b1, 0, "R6 zero base");
      ovr[32'h0032_B000] = 32'h8040_0000;
      do_walk(32'hFFFF_F000, 1'b1, 0, "R2 top index");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule